// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block sits beside an instruction sequencer and decides, at each instruction boundary, whether to enter an interrupt. It accepts a level-sensitive maskable request, gated by the interrupt-enable flag, and an edge-sensitive non-maskable request. The non-maskable request is latched until it is served and always wins over the maskable one. For a maskable request the block runs two acknowledge cycles and takes the 8-bit type byte from the second. A non-maskable entry uses the fixed type 2 and runs no acknowledge cycles.

The type is scaled by four to form an address inside the lowest kilobyte of memory. The block reads two 16-bit words there: first the new instruction offset, then the new code segment. It presents both with a one-cycle valid pulse, together with the 20-bit physical address they form (segment shifted left by four, plus offset). After reset the outputs point at the restart location FFFF0h.

Both outward ports follow valid/ready rules. A request stays asserted, with its address and phase held unchanged, until the cycle in which ready is high. Ready may be held high with no request pending. The memory side returns exactly one response per accepted read. The block takes it in the cycle `rsp_valid` is high and ignores `rsp_valid` while no read is outstanding.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While reset is held and after it is released, code segment = FFFFh, instruction offset = 0000h and physical address = FFFF0h; `vec_valid`, `rd_valid` and `ack_valid` are low until an entry starts.
- R2: A maskable entry starts on an `insn_end` cycle only if `intr_lvl` was high in the preceding cycle and `ien_flag` is high; an `intr_lvl` that is high only during the `insn_end` cycle itself starts nothing.
- R3: While `ien_flag` is low, `intr_lvl` has no effect: no acknowledge cycle, no read and no `vec_valid`.
- R4: A maskable entry runs exactly two acknowledge handshakes, the first with `ack_second`=0 and the second with `ack_second`=1. Each request holds `ack_valid` and `ack_second` until `ack_ready`. The type is `ack_type` sampled at the second handshake; the value at the first handshake is ignored.
- R5: The table address is type×4 (type in address bits 9:2, bits 1:0 zero). The offset word is read from that address and the segment word from that address + 2. Every read address lies below 400h.
- R6: `rd_valid` and `rd_addr` stay unchanged until `rd_ready` is high. A response is taken only while one is outstanding.
- R7: A rising edge on `nmi_pin` is latched and entered at the next `insn_end` with type 2 (address 008h) and no acknowledge cycles. A pending NMI is served before a maskable request presented at the same boundary.
- R8: An `nmi_pin` rising edge that arrives at either of the first two clock edges after reset release is discarded. Reset clears a pending NMI.
- R9: `vec_valid` is high for exactly one cycle per entry. In that cycle `new_cs` and `new_ip` carry the segment and offset that were read, and `phys_addr` = `new_cs`×16 + `new_ip` (20 bits). The outputs hold these values afterwards.
- R10: An `insn_end` that arrives while an entry is in progress (`busy`=1) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| intr_lvl | input | 1 | Maskable request level |
| nmi_pin | input | 1 | Non-maskable request, rising-edge sensitive |
| ien_flag | input | 1 | Interrupt-enable flag |
| insn_end | input | 1 | Instruction boundary strobe |
| busy | output | 1 | Entry sequence in progress |
| ack_valid | output | 1 | Acknowledge cycle request |
| ack_second | output | 1 | 0 = first acknowledge cycle, 1 = second |
| ack_ready | input | 1 | Acknowledge cycle accepted |
| ack_type | input | 8 | Type byte, sampled on the second handshake |
| rd_valid | output | 1 | Word read request |
| rd_addr | output | 20 | Word read address |
| rd_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data |
| vec_valid | output | 1 | One-cycle pulse: new pointer ready |
| new_cs | output | 16 | Code segment |
| new_ip | output | 16 | Instruction offset |
| phys_addr | output | 20 | Segment×16 + offset |

## Verification
The bench goes after the recognition window of the maskable request. A request raised only in the boundary cycle must be refused, and a design that sampled the level in that same cycle would enter anyway. It gives a different byte on the first acknowledge, so a design that captured the wrong cycle loads its pointer from the wrong slot. It uses types 00h and FFh, and a reversed or mis-shifted table address would fetch outside 000h–3FFh or swap the two words. It also raises NMI together with a maskable request, pulses NMI right at reset release and across a reset, and strobes the boundary while busy. These catch a lost priority, an edge honoured too early, a stale pending latch and a doubled entry, each of which shows up as an extra or out-of-order pointer.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned TYPE_W   = 8;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned ADDR_W   = WORD_W + 4;
  localparam int unsigned NMI_TYPE = 2;
  localparam logic [WORD_W-1:0] RESET_CS = '1;
  localparam logic [WORD_W-1:0] RESET_IP = '0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK1,
    ST_ACK2,
    ST_RD_OFF,
    ST_WT_OFF,
    ST_RD_SEG,
    ST_WT_SEG
  } entry_st_t;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch #(
  parameter int unsigned GUARD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pin,
  input  logic clr,
  output logic pend
);
  localparam int unsigned CNT_W = $clog2(GUARD_CYC + 1);

  logic [CNT_W-1:0] guard_cnt;
  logic             nmi_prev;
  logic             armed;
  logic             edge_seen;

  assign armed     = (guard_cnt == CNT_W'(GUARD_CYC));
  assign edge_seen = nmi_pin & ~nmi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_cnt <= '0;
      nmi_prev  <= 1'b0;
      pend      <= 1'b0;
    end else begin
      nmi_prev <= nmi_pin;
      if (!armed) guard_cnt <= guard_cnt + 1'b1;
      pend <= (pend & ~clr) | (edge_seen & armed);
    end
  end

  // R8
  nmi_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !pend);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic intr_lvl,
  input  logic ien_flag,
  input  logic insn_end,
  input  logic idle,
  input  logic nmi_pend,
  output logic take_nmi,
  output logic take_intr
);
  logic intr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intr_q <= 1'b0;
    else        intr_q <= intr_lvl;
  end

  always_comb begin
    take_nmi  = insn_end & idle & nmi_pend;
    take_intr = insn_end & idle & ~nmi_pend & intr_q & ien_flag;
  end

  // R2
  intr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr |-> $past(intr_lvl));
endmodule

// File: rtl/irq_vec_fetch.sv
module irq_vec_fetch
  import irq_pkg::*;
#(
  parameter int unsigned TW = TYPE_W,
  parameter int unsigned DW = WORD_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NMI_T = NMI_TYPE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_nmi,
  input  logic          take_intr,
  output logic          ack_valid,
  output logic          ack_second,
  input  logic          ack_ready,
  input  logic [TW-1:0] ack_type,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          vec_valid,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] ip_o,
  output logic          idle
);
  localparam int unsigned TBL_W = TW + 2;

  entry_st_t     st;
  logic [AW-1:0] vec_q;
  logic [DW-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      vec_q     <= '0;
      off_q     <= '0;
      cs_o      <= RESET_CS;
      ip_o      <= RESET_IP;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (take_nmi) begin
            vec_q <= AW'(NMI_T) << 2;
            st    <= ST_RD_OFF;
          end else if (take_intr) begin
            st <= ST_ACK1;
          end
        end
        ST_ACK1: if (ack_ready) st <= ST_ACK2;
        ST_ACK2: begin
          if (ack_ready) begin
            vec_q <= AW'({ack_type, 2'b00});
            st    <= ST_RD_OFF;
          end
        end
        ST_RD_OFF: if (rd_ready) st <= ST_WT_OFF;
        ST_WT_OFF: begin
          if (rsp_valid) begin
            off_q <= rsp_data;
            st    <= ST_RD_SEG;
          end
        end
        ST_RD_SEG: if (rd_ready) st <= ST_WT_SEG;
        ST_WT_SEG: begin
          if (rsp_valid) begin
            cs_o      <= rsp_data;
            ip_o      <= off_q;
            vec_valid <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle       = (st == ST_IDLE);
    ack_valid  = (st == ST_ACK1) || (st == ST_ACK2);
    ack_second = (st == ST_ACK2);
    rd_valid   = (st == ST_RD_OFF) || (st == ST_RD_SEG);
    rd_addr    = (st == ST_RD_SEG) ? vec_q + AW'(2) : vec_q;
  end

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_second)));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R5
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr >> TBL_W) == '0);

  // R9
  vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned TW        = TYPE_W,
  parameter int unsigned DW        = WORD_W,
  parameter int unsigned GUARD_CYC = 2,
  parameter int unsigned NMI_T     = NMI_TYPE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               intr_lvl,
  input  logic               nmi_pin,
  input  logic               ien_flag,
  input  logic               insn_end,
  output logic               busy,
  output logic               ack_valid,
  output logic               ack_second,
  input  logic               ack_ready,
  input  logic [TW-1:0]      ack_type,
  output logic               rd_valid,
  output logic [DW+4-1:0]    rd_addr,
  input  logic               rd_ready,
  input  logic               rsp_valid,
  input  logic [DW-1:0]      rsp_data,
  output logic               vec_valid,
  output logic [DW-1:0]      new_cs,
  output logic [DW-1:0]      new_ip,
  output logic [DW+4-1:0]    phys_addr
);
  localparam int unsigned AW = DW + 4;

  logic nmi_pend;
  logic take_nmi;
  logic take_intr;
  logic idle;

  irq_nmi_latch #(.GUARD_CYC(GUARD_CYC)) u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_pin (nmi_pin),
    .clr     (take_nmi),
    .pend    (nmi_pend)
  );

  irq_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .intr_lvl  (intr_lvl),
    .ien_flag  (ien_flag),
    .insn_end  (insn_end),
    .idle      (idle),
    .nmi_pend  (nmi_pend),
    .take_nmi  (take_nmi),
    .take_intr (take_intr)
  );

  irq_vec_fetch #(.TW(TW), .DW(DW), .AW(AW), .NMI_T(NMI_T)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_nmi   (take_nmi),
    .take_intr  (take_intr),
    .ack_valid  (ack_valid),
    .ack_second (ack_second),
    .ack_ready  (ack_ready),
    .ack_type   (ack_type),
    .rd_valid   (rd_valid),
    .rd_addr    (rd_addr),
    .rd_ready   (rd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .vec_valid  (vec_valid),
    .cs_o       (new_cs),
    .ip_o       (new_ip),
    .idle       (idle)
  );

  assign busy      = ~idle;
  assign phys_addr = AW'({new_cs, 4'b0000}) + AW'(new_ip);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && insn_end && !vec_valid) |=> !(ack_valid && !$past(ack_valid)));
endmodule

// File: tb/irq_entry_ctrl_bench.sv
`timescale 1ns/1ps
module irq_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        intr_lvl, nmi_pin, ien_flag, insn_end;
  logic        busy, ack_valid, ack_second, ack_ready;
  logic [7:0]  ack_type;
  logic        rd_valid, rd_ready, rsp_valid;
  logic [19:0] rd_addr, phys_addr;
  logic [15:0] rsp_data, new_cs, new_ip;
  logic        vec_valid;

  always #2.5 clk = ~clk;

  irq_entry_ctrl u_irq_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .intr_lvl(intr_lvl), .nmi_pin(nmi_pin),
    .ien_flag(ien_flag), .insn_end(insn_end), .busy(busy),
    .ack_valid(ack_valid), .ack_second(ack_second), .ack_ready(ack_ready),
    .ack_type(ack_type), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .vec_valid(vec_valid), .new_cs(new_cs), .new_ip(new_ip),
    .phys_addr(phys_addr)
  );

  int total = 0;
  int bad = 0;
  int vec_seen = 0;
  int ack_hs = 0;
  int rd_hs = 0;
  int cyc = 0;
  bit done = 0;
  bit stall = 0;
  int lat = 1;
  logic [7:0] tb_type = 8'h00;
  logic [31:0] exp_q[$];

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return (a[15:0] * 16'd37) ^ 16'h5A5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_entry(input logic [19:0] vec);
    exp_q.push_back({mem_word(vec + 20'd2), mem_word(vec)});
  endtask

  task automatic pulse_end();
    @(negedge clk) insn_end = 1'b1;
    @(negedge clk) insn_end = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // responders: decide ready, note handshakes, deliver read data
  int rsp_cnt = 0;
  logic [19:0] rsp_addr;
  always @(negedge clk) begin
    cyc++;
    rsp_valid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = mem_word(rsp_addr);
      end
    end
    rd_ready  = stall ? (cyc % 3 == 0) : 1'b1;
    ack_ready = stall ? (cyc % 4 == 1) : 1'b1;
    if (rd_valid && rd_ready && rst_n) begin
      rsp_addr = rd_addr;
      rsp_cnt  = lat;
      rd_hs++;
    end
    if (ack_valid && ack_ready && rst_n) begin
      ack_type = ack_second ? tb_type : 8'h99;
      ack_hs++;
    end
  end

  // monitor: scoreboard compare at every pointer pulse (R9)
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      vec_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected entry", {new_cs, new_ip}, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check({new_cs, new_ip} == e, "R5 R9 pointer", {new_cs, new_ip}, e);
        check(phys_addr == ({new_cs, 4'h0} + {4'h0, new_ip}), "R9 phys",
              {12'h0, phys_addr}, {12'h0, ({new_cs, 4'h0} + {4'h0, new_ip})});
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v0, a0;
    rst_n = 1'b0; intr_lvl = 0; nmi_pin = 0; ien_flag = 0; insn_end = 0;
    ack_type = 8'h00; rsp_data = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(new_cs == 16'hFFFF && new_ip == 16'h0000, "R1 pointer in reset",
          {new_cs, new_ip}, 32'hFFFF0000);
    // R8: nmi rising together with reset release
    rst_n = 1'b1; nmi_pin = 1'b1;
    @(negedge clk);
    check(phys_addr == 20'hFFFF0, "R1 phys after reset", {12'h0, phys_addr},
          32'h000FFFF0);
    check(!vec_valid && !rd_valid && !ack_valid, "R1 idle outputs",
          {29'h0, vec_valid, rd_valid, ack_valid}, 32'h0);
    repeat (3) @(negedge clk);
    nmi_pin = 1'b0;
    v0 = vec_seen;
    pulse_end();
    settle(4);
    check(vec_seen == v0 && rd_hs == 0, "R8 early nmi discarded",
          vec_seen - v0, 0);

    // R3: masked intr
    intr_lvl = 1'b1; tb_type = 8'h33;
    repeat (2) @(negedge clk);
    pulse_end();
    settle(4);
    check(ack_hs == 0 && vec_seen == v0, "R3 masked intr ignored", ack_hs, 0);
    intr_lvl = 1'b0;
    @(negedge clk);

    // R2: intr only in the boundary cycle
    ien_flag = 1'b1;
    @(negedge clk) begin intr_lvl = 1'b1; insn_end = 1'b1; end
    @(negedge clk) begin intr_lvl = 1'b0; insn_end = 1'b0; end
    settle(4);
    check(ack_hs == 0 && vec_seen == v0, "R2 late intr refused", ack_hs, 0);

    // R2 R4 R5: normal entry, type 21h
    tb_type = 8'h21; a0 = ack_hs;
    expect_entry(20'h00084);
    intr_lvl = 1'b1;
    pulse_end();
    intr_lvl = 1'b0;
    settle(2);
    check(ack_hs - a0 == 2, "R4 two acknowledge cycles", ack_hs - a0, 2);
    check(vec_seen == v0 + 1, "R2 entry taken", vec_seen - v0, 1);

    // R5 R6: top type with stalls and latency
    stall = 1; lat = 3; tb_type = 8'hFF;
    expect_entry(20'h003FC);
    intr_lvl = 1'b1;
    pulse_end();
    intr_lvl = 1'b0;
    settle(2);
    check(vec_seen == v0 + 2, "R6 stalled entry done", vec_seen - v0, 2);

    // R5: type 00h
    stall = 0; lat = 1; tb_type = 8'h00;
    expect_entry(20'h00000);
    intr_lvl = 1'b1;
    pulse_end();
    intr_lvl = 1'b0;
    settle(2);
    check(vec_seen == v0 + 3, "R5 type zero entry", vec_seen - v0, 3);

    // R7: nmi alone, no acknowledge
    a0 = ack_hs;
    expect_entry(20'h00008);
    @(negedge clk) nmi_pin = 1'b1;
    @(negedge clk) nmi_pin = 1'b0;
    pulse_end();
    settle(2);
    check(ack_hs == a0, "R7 nmi without acknowledge", ack_hs - a0, 0);
    check(vec_seen == v0 + 4, "R7 nmi entry", vec_seen - v0, 4);

    // R7 priority, R10 boundary while busy
    tb_type = 8'h40; a0 = ack_hs;
    expect_entry(20'h00008);
    expect_entry(20'h00100);
    intr_lvl = 1'b1;
    @(negedge clk) nmi_pin = 1'b1;
    @(negedge clk) nmi_pin = 1'b0;
    pulse_end();
    check(busy == 1'b1, "R10 busy during entry", {31'h0, busy}, 1);
    check(ack_hs == a0, "R7 nmi before intr", ack_hs - a0, 0);
    pulse_end();
    settle(2);
    check(vec_seen == v0 + 5 && ack_hs == a0, "R10 busy strobe ignored",
          vec_seen - v0, 5);
    pulse_end();
    intr_lvl = 1'b0;
    settle(2);
    check(vec_seen == v0 + 6 && ack_hs - a0 == 2, "R7 intr after nmi",
          vec_seen - v0, 6);

    // R8: reset clears pending nmi, R1 pointer restored
    @(negedge clk) nmi_pin = 1'b1;
    @(negedge clk) nmi_pin = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(new_cs == 16'hFFFF && new_ip == 16'h0000, "R1 pointer after re-reset",
          {new_cs, new_ip}, 32'hFFFF0000);
    repeat (3) @(negedge clk);
    pulse_end();
    settle(4);
    check(vec_seen == v0 + 6, "R8 pending nmi cleared by reset",
          vec_seen - v0, 6);
    check(exp_q.size() == 0, "R9 all expected entries seen", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule